// File: doc/BRIEF.md
# Dual Event Performance Counter

This block watches a vector of single-cycle event pulses coming from a link interface and counts two of them at once. Each of the two channels has its own 8-bit event code. The code is an index into the event vector. For example, code 40 picks the received-message pulse and code 104 picks the posted-request-sent pulse. A code that points past the end of the vector never counts.

Software controls the block through four word registers, using a write strobe with address and data and a read strobe whose data returns one cycle later. One control word starts, stops and clears both counters. The same word can also copy the live counts into shadow copies. Every read returns the shadow copies, so a stop-and-capture command gives a consistent pair of values. Each count is wider than one read word. Its low part comes back in its own count register, and its remaining upper bits come back in the select register next to the event codes. Software rebuilds the full value by shifting the upper field left past the low part and ORing the two.

The run control is a two-state machine. ST_STOP holds both counters. ST_RUN counts selected events. A control write with the run bit set moves ST_STOP to ST_RUN. A control write with the run bit clear moves ST_RUN to ST_STOP. Any other write leaves the state where it is.

Top module: `evtmon_top`

## Requirements
- R1: After reset, both live counters, both shadow copies and both event codes are zero, the machine is in ST_STOP, and reads of all four addresses return 0.
- R2: Address 0 holds the event codes: channel 0 in bits [7:0] and channel 1 in bits [15:8]. While running, a channel adds one for every cycle in which event line `evt_i[code]` is high, so code 40 counts line 40 and code 104 counts line 104.
- R3: A code equal to or above the number of event lines counts nothing.
- R4: At address 1, bit 0 of a write selects run (1) or stop (0). A read of address 1 returns the current run state in bit 0. Events that arrive while stopped leave the counters unchanged.
- R5: At address 1, bit 2 of a write clears both counters in the write cycle, and an event in that same cycle is dropped. Writing 0x5 clears the counters and counts from the next cycle on.
- R6: At address 1, bit 1 of a write loads each shadow with its counter's value after that cycle, including an event in the write cycle. Writing 0x2 stops the counters and captures both values together.
- R7: A shadow holds its value until the next load, even while its counter keeps running. Reads return only the shadow values.
- R8: Addresses 2 and 3 return the low LOW_W bits of shadows 0 and 1, zero-extended to 32 bits. The upper bits of shadows 0 and 1 appear at address 0 starting at bits 16 and 24, so the count equals (upper << LOW_W) | low.
- R9: A counter wraps to zero after its all-ones value (modulo 2^CNT_W).
- R10: A read strobe at a clock edge puts the addressed word on `rd_data` after that edge. `rd_data` keeps its value when no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_EVT | Event pulse vector, one line per event code |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_valid | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Read data, one cycle after the strobe |

## Verification
Two pairs of actions can land in the same cycle, and each pair is tested on purpose.

- **Clear and event together.** The bench writes 0x5 while the selected event line is high in that very cycle. The event must be dropped, and the count after the following pulses must hold only those later pulses.
- **Load and event together.** The bench writes 0x2 while an event is high. The captured shadow must include that last event, and the run bit must then read back as zero.

// File: rtl/evtmon_pkg.sv
package evtmon_pkg;
    localparam int NUM_CH       = 2;
    localparam int REG_W        = 32;
    localparam int CTL_RUN_BIT  = 0;
    localparam int CTL_LOAD_BIT = 1;
    localparam int CTL_CLR_BIT  = 2;
    localparam int CMD_W        = 3;
    localparam int SEL0_LSB     = 0;
    localparam int SEL1_LSB     = 8;
    localparam int UP0_LSB      = 16;
    localparam int UP1_LSB      = 24;

    typedef enum logic [1:0] {
        ADDR_SELSTAT = 2'd0,
        ADDR_CTRL    = 2'd1,
        ADDR_LOW0    = 2'd2,
        ADDR_LOW1    = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/evtmon_ctrl.sv
module evtmon_ctrl
    import evtmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [1:0]       wr_addr,
    input  logic [CMD_W-1:0] wr_cmd,
    output logic             run_o,
    output logic             clr_o,
    output logic             load_o
);
    run_state_e state_q;
    run_state_e state_d;
    logic       ctl_wr;

    assign ctl_wr = wr_valid && (wr_addr == ADDR_CTRL);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (ctl_wr &&  wr_cmd[CTL_RUN_BIT]) state_d = ST_RUN;
            ST_RUN:  if (ctl_wr && !wr_cmd[CTL_RUN_BIT]) state_d = ST_STOP;
            default: state_d = ST_STOP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        run_o  = (state_q == ST_RUN);
        clr_o  = ctl_wr && wr_cmd[CTL_CLR_BIT];
        load_o = ctl_wr && wr_cmd[CTL_LOAD_BIT];
    end
endmodule

// File: rtl/evtmon_chan.sv
module evtmon_chan #(
    parameter int NUM_EVT = 128,
    parameter int SEL_W   = 8,
    parameter int CNT_W   = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               run_i,
    input  logic               clr_i,
    input  logic               load_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [CNT_W-1:0]   shd_o
);
    localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    logic             hit;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] shd_q;

    // event picker: codes beyond the vector select nothing
    always_comb begin
        hit = 1'b0;
        if (32'(sel_i) < NUM_EVT) hit = evt_i[sel_i[IDX_W-1:0]];
    end

    always_comb begin
        if (clr_i)              cnt_nx = '0;
        else if (run_i && hit)  cnt_nx = cnt_q + CNT_W'(1);
        else                    cnt_nx = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            shd_q <= '0;
        end else begin
            cnt_q <= cnt_nx;
            if (load_i) shd_q <= cnt_nx;
        end
    end

    assign cnt_o = cnt_q;
    assign shd_o = shd_q;
endmodule

// File: rtl/evtmon_regs.sv
module evtmon_regs
    import evtmon_pkg::*;
#(
    parameter int SEL_W = 8,
    parameter int CNT_W = 40,
    parameter int LOW_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [1:0]       wr_addr,
    input  logic [15:0]      wr_sel,
    input  logic             rd_valid,
    input  logic [1:0]       rd_addr,
    input  logic             run_i,
    input  logic [CNT_W-1:0] shd0_i,
    input  logic [CNT_W-1:0] shd1_i,
    output logic [SEL_W-1:0] sel0_o,
    output logic [SEL_W-1:0] sel1_o,
    output logic [REG_W-1:0] rd_data
);
    localparam int UP_W = CNT_W - LOW_W;

    logic [SEL_W-1:0] sel0_q, sel1_q;
    logic [REG_W-1:0] selstat_w;
    logic [REG_W-1:0] rd_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel0_q <= '0;
            sel1_q <= '0;
        end else if (wr_valid && wr_addr == ADDR_SELSTAT) begin
            sel0_q <= wr_sel[SEL0_LSB +: SEL_W];
            sel1_q <= wr_sel[SEL1_LSB +: SEL_W];
        end
    end

    always_comb begin
        selstat_w = '0;
        selstat_w[SEL0_LSB +: SEL_W] = sel0_q;
        selstat_w[SEL1_LSB +: SEL_W] = sel1_q;
        selstat_w[UP0_LSB +: UP_W]   = shd0_i[CNT_W-1:LOW_W];
        selstat_w[UP1_LSB +: UP_W]   = shd1_i[CNT_W-1:LOW_W];
    end

    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            ADDR_SELSTAT: rd_nx = selstat_w;
            ADDR_CTRL:    rd_nx = REG_W'(run_i);
            ADDR_LOW0:    rd_nx = REG_W'(shd0_i[LOW_W-1:0]);
            ADDR_LOW1:    rd_nx = REG_W'(shd1_i[LOW_W-1:0]);
            default:      rd_nx = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rd_data <= '0;
        else if (rd_valid) rd_data <= rd_nx;
    end

    assign sel0_o = sel0_q;
    assign sel1_o = sel1_q;
endmodule

// File: rtl/evtmon_top.sv
module evtmon_top
    import evtmon_pkg::*;
#(
    parameter int NUM_EVT = 128,
    parameter int SEL_W   = 8,
    parameter int CNT_W   = 40,
    parameter int LOW_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               wr_valid,
    input  logic [1:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               rd_valid,
    input  logic [1:0]         rd_addr,
    output logic [31:0]        rd_data
);
    logic             run_w, clr_w, load_w;
    logic [SEL_W-1:0] sel_w [NUM_CH];
    logic [CNT_W-1:0] cnt_w [NUM_CH];
    logic [CNT_W-1:0] shd_w [NUM_CH];
    logic             unused_wdata;

    assign unused_wdata = ^wr_data[31:16];

    evtmon_ctrl ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_valid(wr_valid),
        .wr_addr (wr_addr),
        .wr_cmd  (wr_data[CMD_W-1:0]),
        .run_o   (run_w),
        .clr_o   (clr_w),
        .load_o  (load_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        evtmon_chan #(
            .NUM_EVT(NUM_EVT),
            .SEL_W  (SEL_W),
            .CNT_W  (CNT_W)
        ) chan_i (
            .clk   (clk),
            .rst_n (rst_n),
            .evt_i (evt_i),
            .sel_i (sel_w[c]),
            .run_i (run_w),
            .clr_i (clr_w),
            .load_i(load_w),
            .cnt_o (cnt_w[c]),
            .shd_o (shd_w[c])
        );
    end

    evtmon_regs #(
        .SEL_W(SEL_W),
        .CNT_W(CNT_W),
        .LOW_W(LOW_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_valid(wr_valid),
        .wr_addr (wr_addr),
        .wr_sel  (wr_data[15:0]),
        .rd_valid(rd_valid),
        .rd_addr (rd_addr),
        .run_i   (run_w),
        .shd0_i  (shd_w[0]),
        .shd1_i  (shd_w[1]),
        .sel0_o  (sel_w[0]),
        .sel1_o  (sel_w[1]),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/evtmon_chk.sv
module evtmon_chk #(
    parameter int CNT_W = 40,
    parameter int LOW_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             clr,
    input logic             load,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] cnt1,
    input logic [CNT_W-1:0] shd0,
    input logic [CNT_W-1:0] shd1,
    input logic             rd_valid,
    input logic [1:0]       rd_addr,
    input logic [31:0]      rd_data
);
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> ($stable(cnt0) && $stable(cnt1))); // R4
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt0 == '0 && cnt1 == '0)); // R5
    AST_LOAD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (shd0 == cnt0 && shd1 == cnt1)); // R6
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(shd0) && $stable(shd1))); // R7
    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |=> (CNT_W'(cnt0 - $past(cnt0)) <= CNT_W'(1))); // R2
    AST_READ_LOW0: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_addr == 2'd2) |=> (rd_data == 32'($past(shd0[LOW_W-1:0])))); // R8
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> $stable(rd_data)); // R10
endmodule

bind evtmon_top evtmon_chk #(.CNT_W(CNT_W), .LOW_W(LOW_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_w),
    .clr     (clr_w),
    .load    (load_w),
    .cnt0    (cnt_w[0]),
    .cnt1    (cnt_w[1]),
    .shd0    (shd_w[0]),
    .shd1    (shd_w[1]),
    .rd_valid(rd_valid),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/evtmon_top_tb_top.sv
module evtmon_top_tb_top;
    localparam int NUM_EVT = 128;
    localparam int LOW_W   = 4;
    localparam int CNT_W   = 8;
    localparam int UP_W    = CNT_W - LOW_W;
    localparam int NVEC    = 5;
    localparam int EV_RX   = 40;
    localparam int EV_TX   = 104;

    // {sel0, sel1, pulses on 40 only, pulses on 104 only, pulses on both}
    localparam logic [39:0] VEC [NVEC] = '{
        {8'd40,  8'd104, 8'd3,  8'd5, 8'd2},
        {8'd104, 8'd40,  8'd20, 8'd0, 8'd0},
        {8'd40,  8'd40,  8'd7,  8'd7, 8'd7},
        {8'd200, 8'd104, 8'd4,  8'd4, 8'd4},
        {8'd5,   8'd104, 8'd0,  8'd0, 8'd0}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_EVT-1:0] evt_i = '0;
    logic               wr_valid = 1'b0;
    logic [1:0]         wr_addr = '0;
    logic [31:0]        wr_data = '0;
    logic               rd_valid = 1'b0;
    logic [1:0]         rd_addr = '0;
    logic [31:0]        rd_data;

    int n_total = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    evtmon_top #(.NUM_EVT(NUM_EVT), .SEL_W(8), .CNT_W(CNT_W), .LOW_W(LOW_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic pulses(input int n_rx, input int n_tx, input int n_both);
        for (int i = 0; i < n_rx; i++) begin
            @(negedge clk); evt_i = '0; evt_i[EV_RX] = 1'b1;
        end
        for (int i = 0; i < n_tx; i++) begin
            @(negedge clk); evt_i = '0; evt_i[EV_TX] = 1'b1;
        end
        for (int i = 0; i < n_both; i++) begin
            @(negedge clk); evt_i = '0; evt_i[EV_RX] = 1'b1; evt_i[EV_TX] = 1'b1;
        end
        @(negedge clk); evt_i = '0;
    endtask

    function automatic logic [CNT_W-1:0] exp_count(input int sel, input int n_rx,
                                                   input int n_tx, input int n_both);
        int t = 0;
        if (sel == EV_RX) t += n_rx + n_both;
        if (sel == EV_TX) t += n_tx + n_both;
        return CNT_W'(t);
    endfunction

    function automatic logic [31:0] exp_sel(input logic [7:0] s0, input logic [7:0] s1,
                                           input logic [CNT_W-1:0] c0, input logic [CNT_W-1:0] c1);
        logic [31:0] w = '0;
        w[7:0]          = s0;
        w[15:8]         = s1;
        w[16 +: UP_W]   = c0[CNT_W-1:LOW_W];
        w[24 +: UP_W]   = c1[CNT_W-1:LOW_W];
        return w;
    endfunction

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, d); check("R1 selstat after reset", d, 32'h0);
        rd(2'd1, d); check("R1 ctrl after reset", d, 32'h0);
        rd(2'd2, d); check("R1 low0 after reset", d, 32'h0);
        rd(2'd3, d); check("R1 low1 after reset", d, 32'h0);

        // Table walk: R2 select/count, R3 unmatched code, R8 split fields
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] s0, s1, a, b, c;
            logic [CNT_W-1:0] e0, e1;
            {s0, s1, a, b, c} = VEC[v];
            e0 = exp_count(int'(s0), int'(a), int'(b), int'(c));
            e1 = exp_count(int'(s1), int'(a), int'(b), int'(c));
            wr(2'd0, {16'h0, s1, s0});
            wr(2'd1, 32'h5);
            pulses(int'(a), int'(b), int'(c));
            wr(2'd1, 32'h2);
            rd(2'd2, d); check($sformatf("R2 R3 R8 vec%0d low0", v), d, 32'(e0[LOW_W-1:0]));
            rd(2'd3, d); check($sformatf("R2 R3 R8 vec%0d low1", v), d, 32'(e1[LOW_W-1:0]));
            rd(2'd0, d); check($sformatf("R2 R8 vec%0d selstat", v), d, exp_sel(s0, s1, e0, e1));
        end

        // R5: clear in the same cycle as an event drops that event
        wr(2'd0, {16'h0, 8'd104, 8'd40});
        wr(2'd1, 32'h5);
        pulses(3, 0, 0);
        @(negedge clk);
        evt_i[EV_RX] = 1'b1; wr_valid = 1'b1; wr_addr = 2'd1; wr_data = 32'h5;
        @(negedge clk);
        evt_i = '0; wr_valid = 1'b0;
        pulses(2, 0, 0);
        wr(2'd1, 32'h2);
        rd(2'd2, d); check("R5 clear drops same-cycle event", d, 32'd2);

        // R6: load in the same cycle as an event includes it
        wr(2'd1, 32'h5);
        pulses(4, 0, 0);
        @(negedge clk);
        evt_i[EV_RX] = 1'b1; wr_valid = 1'b1; wr_addr = 2'd1; wr_data = 32'h2;
        @(negedge clk);
        evt_i = '0; wr_valid = 1'b0;
        rd(2'd2, d); check("R6 load includes same-cycle event", d, 32'd5);
        rd(2'd1, d); check("R4 run bit clear after 0x2", d, 32'h0);

        // R4: events while stopped do nothing
        pulses(6, 0, 0);
        wr(2'd1, 32'h2);
        rd(2'd2, d); check("R4 stopped ignores events", d, 32'd5);

        // R7: shadow holds while counter runs; resume without clear
        wr(2'd1, 32'h1);
        rd(2'd1, d); check("R4 run bit set after 0x1", d, 32'h1);
        pulses(3, 0, 0);
        rd(2'd2, d); check("R7 shadow holds without load", d, 32'd5);
        wr(2'd1, 32'h3);
        rd(2'd2, d); check("R7 load after resume", d, 32'd8);
        wr(2'd1, 32'h0);

        // R9: wrap modulo 2^CNT_W
        wr(2'd1, 32'h5);
        pulses(258, 0, 0);
        wr(2'd1, 32'h2);
        rd(2'd2, d); check("R9 wrap low0", d, 32'd2);
        rd(2'd0, d); check("R9 wrap upper0", d, exp_sel(8'd40, 8'd104, CNT_W'(2), CNT_W'(0)));

        // R10: rd_data holds without a read strobe
        rd(2'd1, held);
        wr(2'd1, 32'h1);
        repeat (4) @(negedge clk);
        check("R10 rd_data held without strobe", rd_data, held);
        wr(2'd1, 32'h0);

        finish_run();
    end
endmodule